// File: doc/BRIEF.md
# Key Matrix Scanner with New-Key and Held Flags

This block scans a key matrix of 10 rows by 8 columns. A prescaler starts one full pass at a fixed interval (about 15 passes per second in the intended system). During a pass the block drives one row index per clock and samples the columns of that row. The first closed contact in row-major order ends the pass. The contact's row and column are then turned into a key code. The table set for that lookup is picked by the shift and control modifier inputs.

The latched code is presented on a data port. Two flags are presented on a status port. The new-key flag tells the processor that a different key has arrived. The held flag tells it that some key was found down during the latest pass. A repeated code does not re-arm the new-key flag, so auto-repeat is left to software. The processor clears the new-key flag by pulling the active-low acknowledge input low.

A three-state machine does the sequencing:
- IDLE waits for the pass tick. Transition "start": clear the held flag and go to row 0.
- SCAN samples one row per cycle. Transition "hit": a column is closed, so capture the translated code and go to LATCH. Transition "next row": no key in a row that is not the last, so stay in SCAN with the next row. Transition "miss": no key in the last row, so load 0xFF and return to IDLE.
- LATCH compares the captured code with the latched one and updates the code and flags. Transition "done": return to IDLE.

Top module: `kbd_scanner`

## Requirements
- R1: After reset the data port reads 0xFF and the status port reads 0x00.
- R2: A pass starts once every SCAN_PERIOD clocks. Rows are driven from 0 upward, one per clock. Within a row the lowest column index wins. The first closed key in row-major order is the only one latched.
- R3: The code is BASE + row*8 + column. BASE is 0 for the plain set, 80 for the shifted set and 160 for the control set. Shift has priority over control when both are held.
- R4: At the start of every pass the held flag is cleared and the new-key flag keeps its value.
- R5: When the key found equals the currently latched code, only the held flag is set; the code and the new-key flag are unchanged.
- R6: When the key found differs from the latched code, the code is replaced and both the new-key and held flags are set.
- R7: A pass that finds no closed key sets the data port to 0xFF, leaves the held flag clear and leaves the new-key flag unchanged.
- R8: While the acknowledge input is low, the new-key flag is cleared. This takes priority over a new key arriving in the same cycle; the code and held flag are still updated.
- R9: Status byte layout: bit 0 is the new-key flag, bit 1 is the held flag, and bits 7..2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_sel | output | 4 | Row index currently driven to the matrix |
| col_in | input | 8 | Column sense lines of the selected row, 1 = closed |
| shift_key | input | 1 | Shift modifier |
| ctrl_key | input | 1 | Control modifier |
| ack_n | input | 1 | Active-low acknowledge, clears the new-key flag |
| key_code | output | 8 | Latched key code, 0xFF when no key is down |
| key_status | output | 8 | Status byte, bit 0 new-key, bit 1 held |

## Verification
The bench presents the same key over consecutive passes. A design that compared the code against the wrong value would re-raise the new-key flag on every pass. It releases all keys and then presses the same key again. Here the intervening 0xFF must re-arm the flag; a design that remembered only the last real key would stay silent. It closes several keys in one pass, including two in the same row, to catch a scan order reversed in either dimension. It holds acknowledge low while a new key arrives, to catch a design that lets the set path beat the clear. Random sparse matrices with random modifiers then exercise the table-set priority and the flag rules against a model kept in the bench.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_LATCH
    } scan_state_t;

    typedef enum logic [1:0] {
        SET_PLAIN,
        SET_SHIFT,
        SET_CTRL
    } table_set_t;

endpackage

// File: rtl/kbd_tick_gen.sv
module kbd_tick_gen #(
    parameter int PERIOD = 8_333_333
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/kbd_col_pick.sv
module kbd_col_pick #(
    parameter int COLS = 8,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [COLS-1:0]  cols,
    output logic             hit,
    output logic [COL_W-1:0] col_idx
);
    // Lowest column index wins: walk down so the last assignment is the lowest.
    always_comb begin
        hit     = |cols;
        col_idx = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (cols[i])
                col_idx = COL_W'(i);
        end
    end
endmodule

// File: rtl/kbd_code_rom.sv
module kbd_code_rom
    import kbd_scan_pkg::*;
#(
    parameter int ROWS       = 10,
    parameter int COLS       = 8,
    parameter int CODE_W     = 8,
    parameter int PLAIN_BASE = 0,
    parameter int SHIFT_BASE = 80,
    parameter int CTRL_BASE  = 160,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  table_set_t        tset,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic [CODE_W-1:0] code
);
    int base;

    always_comb begin
        unique case (tset)
            SET_SHIFT: base = SHIFT_BASE;
            SET_CTRL:  base = CTRL_BASE;
            default:   base = PLAIN_BASE;
        endcase
        code = CODE_W'(base + int'(row) * COLS + int'(col));
    end
endmodule

// File: rtl/kbd_scanner.sv
module kbd_scanner
    import kbd_scan_pkg::*;
#(
    parameter int ROWS        = 10,
    parameter int COLS        = 8,
    parameter int CODE_W      = 8,
    parameter int SCAN_PERIOD = 8_333_333,
    parameter int PLAIN_BASE  = 0,
    parameter int SHIFT_BASE  = 80,
    parameter int CTRL_BASE   = 160,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ROW_W-1:0]  row_sel,
    input  logic [COLS-1:0]   col_in,
    input  logic              shift_key,
    input  logic              ctrl_key,
    input  logic              ack_n,
    output logic [CODE_W-1:0] key_code,
    output logic [7:0]        key_status
);
    localparam logic [ROW_W-1:0]  LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [CODE_W-1:0] NO_KEY   = {CODE_W{1'b1}};

    scan_state_t       state_q, state_d;
    logic              tick, hit;
    logic [COL_W-1:0]  col_idx;
    table_set_t        tset;
    logic [CODE_W-1:0] rom_code;
    logic [ROW_W-1:0]  row_q;
    logic [CODE_W-1:0] found_q, code_q;
    logic              new_q, held_q;
    logic              take_new;

    kbd_tick_gen #(.PERIOD(SCAN_PERIOD)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    kbd_col_pick #(.COLS(COLS)) u_pick (
        .cols    (col_in),
        .hit     (hit),
        .col_idx (col_idx)
    );

    // Shift beats control (R3)
    always_comb begin
        if (shift_key)     tset = SET_SHIFT;
        else if (ctrl_key) tset = SET_CTRL;
        else               tset = SET_PLAIN;
    end

    kbd_code_rom #(
        .ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W),
        .PLAIN_BASE(PLAIN_BASE), .SHIFT_BASE(SHIFT_BASE), .CTRL_BASE(CTRL_BASE)
    ) u_rom (
        .tset (tset),
        .row  (row_q),
        .col  (col_idx),
        .code (rom_code)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick) state_d = ST_SCAN;
            ST_SCAN: begin
                if (hit)                    state_d = ST_LATCH;
                else if (row_q == LAST_ROW) state_d = ST_IDLE;
            end
            ST_LATCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign take_new = (state_q == ST_LATCH) && (found_q != code_q);

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            found_q <= NO_KEY;
            code_q  <= NO_KEY;
            held_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tick) begin
                        row_q  <= '0;
                        held_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (hit)                    found_q <= rom_code;
                    else if (row_q != LAST_ROW) row_q   <= row_q + ROW_W'(1);
                    else                        code_q  <= NO_KEY;
                end
                ST_LATCH: begin
                    held_q <= 1'b1;
                    if (take_new) code_q <= found_q;
                end
                default: ;
            endcase
        end
    end

    // New-key flag: acknowledge wins over arrival (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        new_q <= 1'b0;
        else if (!ack_n)   new_q <= 1'b0;
        else if (take_new) new_q <= 1'b1;
    end

    assign row_sel    = row_q;
    assign key_code   = code_q;
    assign key_status = {6'b0, held_q, new_q};

    a_r2_row_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !hit && row_q != LAST_ROW) |=> row_sel == $past(row_sel) + ROW_W'(1));

    a_r4_held_cleared_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tick) |=> !key_status[1]);

    a_r5_repeat_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && found_q == code_q) |=> (key_code == $past(key_code)) && key_status[1]);

    a_r7_miss_gives_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !hit && row_q == LAST_ROW) |=> (key_code == NO_KEY) && !key_status[1]);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> !key_status[0]);
endmodule

// File: tb/tb_kbd_scanner.sv
module tb_kbd_scanner;
    localparam int ROWS = 10;
    localparam int COLS = 8;
    localparam int P    = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  row_sel;
    logic [7:0]  col_in;
    logic        shift_key = 1'b0, ctrl_key = 1'b0, ack_n = 1'b1;
    logic [7:0]  key_code, key_status;
    logic [ROWS*COLS-1:0] mat = '0;

    int checks = 0, errors = 0;
    logic [7:0] exp_code = 8'hFF;
    logic exp_new = 1'b0, exp_held = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign col_in = mat[row_sel*COLS +: COLS];

    kbd_scanner #(.SCAN_PERIOD(P)) dut (
        .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .col_in(col_in),
        .shift_key(shift_key), .ctrl_key(ctrl_key), .ack_n(ack_n),
        .key_code(key_code), .key_status(key_status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Expected code of the first closed key, 0xFF when none
    function automatic logic [7:0] first_code(input logic [ROWS*COLS-1:0] m, input logic sh, input logic ct);
        int base = sh ? 80 : (ct ? 160 : 0);
        for (int i = 0; i < ROWS*COLS; i++)
            if (m[i]) return 8'(base + i);
        return 8'hFF;
    endfunction

    // mode 0: no ack, 1: ack held low for the whole period, 2: one-cycle ack pulse first
    task automatic run_scan(input logic [ROWS*COLS-1:0] m, input logic sh, input logic ct,
                            input int mode, input string req);
        logic [7:0] fc;
        mat = m; shift_key = sh; ctrl_key = ct;
        if (mode == 2) begin
            ack_n = 1'b0;
            @(negedge clk);
            ack_n = 1'b1;
            exp_new = 1'b0;
            check("R8 ack pulse code", key_code, exp_code);
            check("R8 ack pulse status", key_status, {6'b0, exp_held, exp_new});
            repeat (P - 1) @(posedge clk);
        end else begin
            ack_n = (mode == 1) ? 1'b0 : 1'b1;
            repeat (P) @(posedge clk);
        end
        @(negedge clk);
        ack_n = 1'b1;
        fc = first_code(m, sh, ct);
        exp_held = 1'b0;
        if (fc == 8'hFF) begin
            exp_code = 8'hFF;
        end else begin
            exp_held = 1'b1;
            if (fc != exp_code) begin
                exp_code = fc;
                exp_new  = 1'b1;
            end
        end
        if (mode == 1) exp_new = 1'b0;
        check({req, " code"}, key_code, exp_code);
        check({req, " status"}, key_status, {6'b0, exp_held, exp_new});
    endtask

    initial begin
        logic [ROWS*COLS-1:0] m, prev;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 reset code", key_code, 8'hFF);
        check("R1/R9 reset status", key_status, 8'h00);
        repeat (P + 15) @(posedge clk);
        @(negedge clk);

        m = '0;
        run_scan(m, 0, 0, 0, "R7 empty matrix");
        m = '0; m[0] = 1'b1;
        run_scan(m, 0, 0, 0, "R6 R3 first key plain");
        run_scan(m, 0, 0, 0, "R5 same key held");
        run_scan(m, 0, 0, 2, "R8 ack then same key");
        run_scan(m, 0, 0, 0, "R5 still held after ack");
        m = '0;
        run_scan(m, 0, 0, 0, "R7 release keeps new flag");
        m[0] = 1'b1;
        run_scan(m, 0, 0, 0, "R6 same key after release re-arms");
        m = '0; m[9*8+7] = 1'b1;
        run_scan(m, 1, 0, 0, "R3 shift last key");
        run_scan(m, 1, 1, 0, "R3 shift beats ctrl");
        run_scan(m, 0, 1, 0, "R3 ctrl set");
        m = '0; m[2*8+5] = 1'b1; m[2*8+3] = 1'b1; m[7*8+0] = 1'b1;
        run_scan(m, 0, 0, 0, "R2 row-major priority");
        m = '0; m[4*8+6] = 1'b1;
        run_scan(m, 0, 0, 1, "R8 ack low beats new key");
        run_scan(m, 0, 0, 0, "R4 R5 held re-set only");

        prev = m;
        for (int n = 0; n < 60; n++) begin
            int k = $urandom_range(0, 9);
            if (k < 3) begin
                m = prev;
            end else begin
                m = '0;
                for (int j = 0; j < (k % 3); j++)
                    m[$urandom_range(0, ROWS*COLS-1)] = 1'b1;
            end
            run_scan(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     ($urandom_range(0, 7) == 0) ? 2 : 0, "R2-random R4 R5 R6 R7");
            prev = m;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule